// File: doc/BRIEF.md
# Software Interrupt Redirection Decision Unit

This unit decides where a software interrupt raised by a task running in virtual-8086 mode is dispatched. A request carries the 8-bit vector, a flag that marks hardware interrupts, the virtual-mode extension enable, the 2-bit I/O privilege level and the base address of the I/O permission bitmap. When the answer depends on the per-vector redirection bitmap, the unit reads one byte of that bitmap through a valid/ready read port. The bitmap holds 256 bits and sits in the 32 bytes just below the I/O permission bitmap.

There are three outcomes. The first sends the interrupt to the protected-mode descriptor table. The second raises a general-protection fault with error code zero. The third sends the interrupt through the task's real-mode vector table at linear address 0. For the third outcome the unit also supplies the 4-byte table entry address. Each result is announced by a one-cycle done pulse and stays on the outputs until the next result.

Top module: `swint_steer`

## Requirements
- R1: A bitmap read is issued on `bm_rd_addr` at byte address `io_map_base - 32 + (vector >> 3)`. Within the returned byte, bit `vector[2:0]` governs the vector. Bit 7 of the top byte governs vector 255, and bit 0 of the lowest byte governs vector 0.
- R2: For a software interrupt with extensions enabled, a fetched bit of 1 together with privilege level 3 yields outcome 1 (protected-mode table).
- R3: A fetched bit of 1 together with privilege level 0, 1 or 2 yields outcome 2 (general-protection fault), and `fault_code` reads 0.
- R4: A fetched bit of 0 yields outcome 3 (real-mode table), with `ivt_addr` equal to vector × 4. For every other outcome `ivt_addr` is 0.
- R5: With extensions disabled, a software interrupt issues no bitmap read. It yields outcome 1 at privilege level 3 and outcome 2 otherwise.
- R6: A hardware interrupt (`src_is_hw` = 1) issues no bitmap read and always yields outcome 1, whatever the privilege level, the enable or the bitmap.
- R7: When no read is needed, `done` pulses in the cycle right after the request is accepted.
- R8: `bm_rd_valid` stays high with a stable `bm_rd_addr` until `bm_rd_ready` is seen. The read data is taken when `bm_rsp_valid` is high after that handshake, and `done` pulses in the following cycle.
- R9: `req_ready` is low from acceptance until the decision is made. A request presented during a lookup is ignored.
- R10: `done` lasts exactly one cycle. `outcome` and `ivt_addr` hold their value between done pulses.
- R11: After reset, `done` and `bm_rd_valid` are 0, `outcome` is 0 (none) and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_vector | input | VEC_W | Interrupt vector |
| src_is_hw | input | 1 | 1 = hardware interrupt, 0 = software |
| ext_en | input | 1 | Virtual-mode extensions enabled |
| io_priv | input | 2 | I/O privilege level |
| io_map_base | input | ADDR_W | Base address of the I/O permission bitmap |
| bm_rd_valid | output | 1 | Bitmap read request |
| bm_rd_ready | input | 1 | Read request taken |
| bm_rd_addr | output | ADDR_W | Bitmap byte address |
| bm_rsp_valid | input | 1 | Read data present |
| bm_rsp_data | input | 8 | Bitmap byte |
| done | output | 1 | One-cycle result pulse |
| outcome | output | 2 | 0 none, 1 protected table, 2 GP fault, 3 real-mode table |
| ivt_addr | output | VEC_W+2 | Real-mode table entry address |
| fault_code | output | 16 | Fault error code |

## Verification
A request that needs no bitmap read produces `done` one cycle after the accepting edge. On the bitmap path the address is due one cycle after acceptance and is held for as long as `bm_rd_ready` stays low. After that, `done` follows the edge that captures `bm_rsp_valid` by one cycle. The bench drives inputs and samples outputs on falling edges. It counts those edges one by one through each phase, so every check lands on the cycle in which its result is due. One cycle later it checks that the pulse has ended and that the result is unchanged.

// File: rtl/swint_steer.sv
module swint_steer #(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              src_is_hw,
  input  logic              ext_en,
  input  logic [1:0]        io_priv,
  input  logic [ADDR_W-1:0] io_map_base,
  output logic              bm_rd_valid,
  input  logic              bm_rd_ready,
  output logic [ADDR_W-1:0] bm_rd_addr,
  input  logic              bm_rsp_valid,
  input  logic [7:0]        bm_rsp_data,
  output logic              done,
  output logic [1:0]        outcome,
  output logic [VEC_W+1:0]  ivt_addr,
  output logic [15:0]       fault_code
);
  localparam int BM_BYTES = (1 << VEC_W) / 8;
  localparam logic [1:0] OC_PROT = 2'd1;
  localparam logic [1:0] OC_GP   = 2'd2;
  localparam logic [1:0] OC_REAL = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT} state_t;
  state_t state;

  logic [VEC_W-1:0] vec_q;
  logic             priv3_q;

  wire accept   = req_valid && req_ready;
  wire need_bm  = ext_en && !src_is_hw;
  wire redirect_bit = bm_rsp_data[vec_q[2:0]];
  wire [ADDR_W-1:0] bm_byte =
    io_map_base - ADDR_W'(BM_BYTES) + ADDR_W'(req_vector[VEC_W-1:3]);

  assign req_ready  = (state == S_IDLE);
  assign fault_code = 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      done        <= 1'b0;
      outcome     <= 2'd0;
      ivt_addr    <= '0;
      bm_rd_valid <= 1'b0;
      bm_rd_addr  <= '0;
      vec_q       <= '0;
      priv3_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          vec_q   <= req_vector;
          priv3_q <= (io_priv == 2'd3);
          if (need_bm) begin
            bm_rd_valid <= 1'b1;
            bm_rd_addr  <= bm_byte;
            state       <= S_RD;
          end else begin
            outcome  <= (src_is_hw || io_priv == 2'd3) ? OC_PROT : OC_GP;
            ivt_addr <= '0;
            done     <= 1'b1;
          end
        end
        S_RD: if (bm_rd_ready) begin
          bm_rd_valid <= 1'b0;
          state       <= S_WAIT;
        end
        S_WAIT: if (bm_rsp_valid) begin
          if (redirect_bit) begin
            outcome  <= priv3_q ? OC_PROT : OC_GP;
            ivt_addr <= '0;
          end else begin
            outcome  <= OC_REAL;
            ivt_addr <= {vec_q, 2'b00};
          end
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swint_steer_chk.sv
module swint_steer_chk #(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              src_is_hw,
  input logic              ext_en,
  input logic              bm_rd_valid,
  input logic              bm_rd_ready,
  input logic [ADDR_W-1:0] bm_rd_addr,
  input logic              done,
  input logic [1:0]        outcome,
  input logic [VEC_W+1:0]  ivt_addr
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_valid && !bm_rd_ready |=> bm_rd_valid && $stable(bm_rd_addr)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_valid |-> !req_ready); // R9

  AST_HW_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && src_is_hw |=> !bm_rd_valid && done && outcome == 2'd1); // R6

  AST_NO_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !ext_en |=> done && !bm_rd_valid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(outcome) && $stable(ivt_addr)); // R10

  AST_REAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    outcome != 2'd3 |-> ivt_addr == '0); // R4
endmodule

bind swint_steer swint_steer_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .src_is_hw(src_is_hw), .ext_en(ext_en), .bm_rd_valid(bm_rd_valid),
  .bm_rd_ready(bm_rd_ready), .bm_rd_addr(bm_rd_addr), .done(done),
  .outcome(outcome), .ivt_addr(ivt_addr)
);

// File: tb/tb_swint_steer.sv
module tb_swint_steer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, src_is_hw = 1'b0, ext_en = 1'b0;
  logic [7:0] req_vector = '0;
  logic [1:0] io_priv = '0;
  logic [15:0] io_map_base = 16'h0100;
  logic bm_rd_ready = 1'b0, bm_rsp_valid = 1'b0;
  logic [7:0] bm_rsp_data = '0;
  logic req_ready, bm_rd_valid, done;
  logic [15:0] bm_rd_addr, fault_code;
  logic [1:0] outcome;
  logic [9:0] ivt_addr;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  swint_steer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector), .src_is_hw(src_is_hw), .ext_en(ext_en),
    .io_priv(io_priv), .io_map_base(io_map_base), .bm_rd_valid(bm_rd_valid),
    .bm_rd_ready(bm_rd_ready), .bm_rd_addr(bm_rd_addr),
    .bm_rsp_valid(bm_rsp_valid), .bm_rsp_data(bm_rsp_data), .done(done),
    .outcome(outcome), .ivt_addr(ivt_addr), .fault_code(fault_code)
  );

  function automatic bit bm_bit(input int v);
    logic [7:0] b = 8'(v);
    return (^(b & 8'hA5)) | (v == 255);
  endfunction

  function automatic logic [7:0] bm_byte(input int idx);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = bm_bit(idx * 8 + j);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic run(input int v, input bit hw, input bit en, input int pl,
                     input logic [15:0] base, input int lat);
    int exp_oc;
    int exp_iv;
    bit need = en && !hw;
    bit bit_v = bm_bit(v);
    logic [15:0] tbl = base - 16'd32;
    if (hw) exp_oc = 1;
    else if (!en || bit_v) exp_oc = (pl == 3) ? 1 : 2;
    else exp_oc = 3;
    exp_iv = (exp_oc == 3) ? v * 4 : 0;

    chk("R9 ready idle", req_ready, 1);
    req_valid = 1; req_vector = 8'(v); src_is_hw = hw; ext_en = en;
    io_priv = 2'(pl); io_map_base = base;
    @(negedge clk);
    req_valid = 0;
    if (need) begin
      chk("R1 read address", bm_rd_addr, tbl + 16'(v >> 3));
      chk("R8 read valid", bm_rd_valid, 1);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk("R8 valid held", {bm_rd_valid, bm_rd_addr}, {1'b1, tbl + 16'(v >> 3)});
      end
      bm_rd_ready = 1;
      @(negedge clk);
      bm_rd_ready = 0;
      chk("R9 busy not ready", {bm_rd_valid, req_ready}, 2'b00);
      req_valid = 1; src_is_hw = 1; req_vector = ~8'(v);
      @(negedge clk);
      chk("R9 ignored during lookup", {done, req_ready}, 2'b00);
      req_valid = 0;
      bm_rsp_valid = 1;
      bm_rsp_data = bm_byte(int'(bm_rd_addr - tbl));
      @(negedge clk);
      bm_rsp_valid = 0;
      chk("R8 done after response", done, 1);
    end else begin
      chk(hw ? "R6 no read" : "R5 no read", bm_rd_valid, 0);
      chk("R7 done next cycle", done, 1);
    end
    if (exp_oc == 3) chk("R4 real table", {outcome, ivt_addr}, {2'(exp_oc), 10'(exp_iv)});
    else if (exp_oc == 2) begin
      chk(need ? "R3 gp fault" : "R5 gp fault", {outcome, ivt_addr}, {2'(exp_oc), 10'(exp_iv)});
      chk("R3 error code", fault_code, 0);
    end else chk(hw ? "R6 protected" : (need ? "R2 protected" : "R5 protected"),
                 {outcome, ivt_addr}, {2'(exp_oc), 10'(exp_iv)});
    @(negedge clk);
    chk("R10 pulse ends", done, 0);
    chk("R10 result held", {outcome, ivt_addr}, {2'(exp_oc), 10'(exp_iv)});
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R11 reset outcome", outcome, 0);
    chk("R11 reset read", bm_rd_valid, 0);
    chk("R11 reset ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < 256; v++)
      run(v, 0, 1, v % 4, 16'h0068 + 16'(v * 3), v % 3);
    for (int v = 0; v < 256; v += 5)
      for (int pl = 0; pl < 4; pl++) run(v, 0, 0, pl, 16'h0400, 0);
    for (int v = 0; v < 256; v += 7)
      for (int pl = 0; pl < 4; pl++) run(v, 1, v % 2, pl, 16'h0200, 0);
    run(255, 0, 1, 3, 16'h0020, 2);
    run(255, 0, 1, 0, 16'h0020, 0);
    run(0, 0, 1, 1, 16'hFFF0, 1);
    report();
  end
endmodule